// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock line of an I2C bus master and tells a separate protocol sequencer when it may move the data line. Every phase of the clock is timed from its own programmable count of input-clock cycles: the whole SCL period, its low part, a single count for the START hold, restart setup and STOP setup, and a data setup margin ahead of each rising edge. For 100 kHz or 400 kHz operation, software loads the period with the input clock rate divided by the bus rate. The low count is typically 5/9 of that, for a 5:4 low-to-high ratio. The condition count is typically half the period and the data setup count about one sixteenth of it.

The sequencer issues one operation at a time: a data bit, a START, a repeated START or a STOP. The block answers with single-cycle strobes: one where SDA may change during the low phase, one where SDA should be sampled, one where SDA must make the START or STOP transition, and one when the operation ends. SCL is treated as open drain. After SCL is released, the high phase is not counted until the synchronised line really reads high, so a slave that stretches the clock is honoured and flagged. A START is held back until the bus has been free for at least the low count.

For bus recovery, software clears the run control. SCL then follows a software release bit, and a four-bit monitor word shows both live line levels and both driven levels.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, with run set, SCL is released (`scl_out`=1), `op_ready` is 1, no strobe is high and `stretch` is 0; both input synchronisers start at 1.
- R2: A data bit (op_code 0) accepted while the bus is owned holds SCL low for max(cfg_low,1) cycles starting the cycle after acceptance, then releases it. Once the high count starts, SCL stays high for max(cfg_period−low,1) cycles. `stb_done` is high in the last high cycle, and SCL is low again in the next cycle.
- R3: `stb_sda_set` is high for exactly one low-phase cycle, at index low−max(cfg_dsu,1) counted from 0, or at index 0 when that margin reaches the low count.
- R4: `stb_sample` is high in the first counted cycle of a data bit's high phase.
- R5: While SCL is released and the synchronised SCL reads low, `stretch` is 1 and no high or setup count advances.
- R6: A START (op_code 1) accepted on a free bus waits until the bus-free counter reaches the low count. It then raises `stb_cond` for one cycle and keeps SCL high for max(cfg_cond,1) cycles from that cycle, with `stb_done` in the last of them. SCL is low afterwards and the bus is owned. The bus-free counter saturates at its maximum.
- R7: A repeated START (op_code 2) runs a low phase as in R2 with `stb_sda_set`. After SCL is seen high it counts max(cfg_cond,1) setup cycles, then raises `stb_cond` and holds for max(cfg_cond,1) cycles with `stb_done` in the last. SCL is low afterwards.
- R8: A STOP (op_code 3) runs a low phase and the setup count as in R7. It then spends one cycle with both `stb_cond` and `stb_done` high, leaves SCL released and the bus free, and restarts the bus-free counter from 0.
- R9: A START on an owned bus, or a bit, repeated START or STOP on a free bus, is ignored. SCL, `op_ready` and all strobes are unchanged.
- R10: With `ctl_run` at 0, `scl_out` equals `ctl_scl_rel`, `op_ready` and all strobes are 0, and the generator returns to a free, idle bus whose free counter restarts from 0.
- R11: `mon` bit 0 is the synchronised SCL level, bit 1 the driven SCL level, bit 2 the synchronised SDA level and bit 3 the sequencer's SDA drive. Each line input reaches its bit after SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CNT_W | Total SCL period (low plus high) |
| cfg_low | input | CNT_W | SCL low count, also the minimum bus-free time |
| cfg_cond | input | CNT_W | START hold, restart setup and STOP setup count |
| cfg_dsu | input | CNT_W | SDA setup margin before the SCL rising edge |
| ctl_run | input | 1 | 1 = normal operation, 0 = software owns SCL |
| ctl_scl_rel | input | 1 | SCL level while `ctl_run` is 0 (1 = release) |
| op_valid | input | 1 | Sequencer presents an operation |
| op_code | input | 2 | 0 bit, 1 START, 2 repeated START, 3 STOP |
| op_ready | output | 1 | Generator idle and able to take an operation |
| sda_drv_i | input | 1 | SDA level the sequencer is driving (1 = released) |
| scl_in | input | 1 | Live SCL line |
| sda_in | input | 1 | Live SDA line |
| scl_out | output | 1 | SCL drive, 0 pulls low, 1 releases |
| stb_sda_set | output | 1 | SDA may change now (low phase) |
| stb_sample | output | 1 | Sample SDA now (first high cycle of a bit) |
| stb_cond | output | 1 | Make the START/STOP SDA transition now |
| stb_done | output | 1 | Last cycle of the current operation |
| stretch | output | 1 | SCL released but held low by another device |
| mon | output | 4 | Line monitor, bit layout in R11 |

## Verification
Two events collide when a STOP finishes and a START is already waiting behind it. In the same cycle the STOP's completion strobe fires, the bus-free counter restarts from zero and the generator becomes ready. The bench issues the START as soon as ready rises, and the reference model must then place `stb_cond` exactly the low count later. The second collision is a recovery takeover that lands in the middle of a data bit's low phase. There the strobe gating and the forced return to a free bus must agree in a single cycle. Both cases are compared on every clock against the behavioural model, together with a clock-stretching slave and a configuration in which every count hits its clamp.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FREEW = 3'd1,
    PH_LOW   = 3'd2,
    PH_WAITH = 3'd3,
    PH_HIGH  = 3'd4,
    PH_SETUP = 3'd5,
    PH_HOLD  = 3'd6
  } sclt_phase_e;

  typedef enum logic [1:0] {
    OP_BIT     = 2'd0,
    OP_START   = 2'd1,
    OP_RESTART = 2'd2,
    OP_STOP    = 2'd3
  } sclt_op_e;

  // A programmed count of zero is treated as one cycle.
  function automatic int unsigned len_min1(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // High part of the period; at least one cycle.
  function automatic int unsigned high_len(input int unsigned period,
                                           input int unsigned low);
    int unsigned lo;
    lo = len_min1(low);
    return (period > lo) ? (period - lo) : 1;
  endfunction

  // Low-phase index at which SDA may change so that dsu cycles remain.
  function automatic int unsigned sda_index(input int unsigned low,
                                            input int unsigned dsu);
    int unsigned lo;
    int unsigned ds;
    lo = len_min1(low);
    ds = len_min1(dsu);
    return (ds >= lo) ? 0 : (lo - ds);
  endfunction

endpackage

// File: rtl/sclt_sync.sv
module sclt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= {STAGES{RST_VAL}};
        else        q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sclt_free_cnt.sv
module sclt_free_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (inc && !at_max)   cnt_q <= cnt_q + ONE;
  end

  assign count = cnt_q;

  // R8 / R10: a clear request empties the bus-free counter
  assert_free_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R6: the bus-free counter never wraps
  assert_free_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && at_max) |=> (count == CNT_MAX));

endmodule

// File: rtl/sclt_phase_fsm.sv
module sclt_phase_fsm
  import sclt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic             scl_sync,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_cond,
  input  logic [CNT_W-1:0] cfg_dsu,
  input  logic [CNT_W-1:0] free_cnt,
  output logic             scl_drv,
  output logic             ready,
  output logic             stb_sda_set,
  output logic             stb_sample,
  output logic             stb_cond,
  output logic             stb_done,
  output logic             stretch,
  output logic             free_inc,
  output logic             stop_done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sclt_phase_e      phase_q, phase_d;
  sclt_op_e         op_q, op_d, op_in;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             owned_q, owned_d;

  // phase lengths from the arithmetic helpers
  logic [CNT_W-1:0] low_len, hi_len, cond_len, sda_idx;
  assign low_len  = CNT_W'(len_min1(32'(cfg_low)));
  assign hi_len   = CNT_W'(high_len(32'(cfg_period), 32'(cfg_low)));
  assign cond_len = CNT_W'(len_min1(32'(cfg_cond)));
  assign sda_idx  = CNT_W'(sda_index(32'(cfg_low), 32'(cfg_dsu)));

  // named events used by the next-state logic and the assertions
  logic low_last, high_last, cond_last, hold_last, op_legal, free_ok;
  assign op_in     = sclt_op_e'(op_code);
  assign low_last  = (cnt_q == low_len - ONE);
  assign high_last = (cnt_q == hi_len - ONE);
  assign cond_last = (cnt_q == cond_len - ONE);
  assign hold_last = (op_q == OP_STOP) ? (cnt_q == '0) : cond_last;
  assign op_legal  = (op_in == OP_START) ? !owned_q : owned_q;
  assign free_ok   = (free_cnt >= low_len);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    owned_d = owned_q;
    if (!run) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      owned_d = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (op_valid && op_legal) begin
            op_d    = op_in;
            cnt_d   = '0;
            phase_d = (op_in == OP_START) ? PH_FREEW : PH_LOW;
          end
        end
        PH_FREEW: begin
          if (free_ok) begin
            phase_d = PH_HOLD;
            cnt_d   = '0;
          end
        end
        PH_LOW: begin
          if (low_last) begin
            phase_d = PH_WAITH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_WAITH: begin
          if (scl_sync) begin
            phase_d = (op_q == OP_BIT) ? PH_HIGH : PH_SETUP;
            cnt_d   = '0;
          end
        end
        PH_HIGH: begin
          if (high_last) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_SETUP: begin
          if (cond_last) begin
            phase_d = PH_HOLD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        PH_HOLD: begin
          if (hold_last) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
            owned_d = (op_q != OP_STOP);
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_BIT;
      owned_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      owned_q <= owned_d;
    end
  end

  // decoded outputs
  assign scl_drv     = !((phase_q == PH_LOW) || ((phase_q == PH_IDLE) && owned_q));
  assign ready       = run && (phase_q == PH_IDLE);
  assign stb_sda_set = run && (phase_q == PH_LOW) && (cnt_q == sda_idx);
  assign stb_sample  = run && (phase_q == PH_HIGH) && (cnt_q == '0);
  assign stb_cond    = run && (phase_q == PH_HOLD) && (cnt_q == '0);
  assign stb_done    = run && (((phase_q == PH_HIGH) && high_last) ||
                               ((phase_q == PH_HOLD) && hold_last));
  assign stretch     = run && (phase_q == PH_WAITH) && !scl_sync;
  assign free_inc    = run && ((phase_q == PH_IDLE) || (phase_q == PH_FREEW)) && !owned_q;
  assign stop_done   = run && (phase_q == PH_HOLD) && (op_q == OP_STOP) && hold_last;

  // R2: the low-phase counter stays inside the programmed low count
  assert_low_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_len));

  // R5: no high or setup count while the line is still held low
  assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (phase_q == PH_WAITH) && !scl_sync) |=>
      ((phase_q != PH_HIGH) && (phase_q != PH_SETUP)));

  // R9: an operation that does not fit the bus state leaves the generator idle
  assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (phase_q == PH_IDLE) && op_valid && !op_legal) |=>
      ((phase_q == PH_IDLE) && (owned_q == $past(owned_q))));

  // R10: recovery returns to an idle, free bus
  assert_recovery_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((phase_q == PH_IDLE) && !owned_q));

  // R6: a START hold never begins before the bus-free time is met
  assert_start_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (phase_q == PH_FREEW) && !free_ok) |=> (phase_q != PH_HOLD));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_cond,
  input  logic [CNT_W-1:0] cfg_dsu,
  input  logic             ctl_run,
  input  logic             ctl_scl_rel,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  output logic             op_ready,
  input  logic             sda_drv_i,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_out,
  output logic             stb_sda_set,
  output logic             stb_sample,
  output logic             stb_cond,
  output logic             stb_done,
  output logic             stretch,
  output logic [3:0]       mon
);

  logic scl_s, sda_s;
  logic scl_drv, free_inc, stop_done, free_clr;
  logic [CNT_W-1:0] free_cnt;

  sclt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s)
  );

  sclt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s)
  );

  sclt_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctl_run),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .scl_sync   (scl_s),
    .cfg_period (cfg_period),
    .cfg_low    (cfg_low),
    .cfg_cond   (cfg_cond),
    .cfg_dsu    (cfg_dsu),
    .free_cnt   (free_cnt),
    .scl_drv    (scl_drv),
    .ready      (op_ready),
    .stb_sda_set(stb_sda_set),
    .stb_sample (stb_sample),
    .stb_cond   (stb_cond),
    .stb_done   (stb_done),
    .stretch    (stretch),
    .free_inc   (free_inc),
    .stop_done  (stop_done)
  );

  assign free_clr = !ctl_run || stop_done;

  sclt_free_cnt #(.CNT_W(CNT_W)) u_free (
    .clk(clk), .rst_n(rst_n), .clr(free_clr), .inc(free_inc), .count(free_cnt)
  );

  // recovery override of the clock drive
  assign scl_out = ctl_run ? scl_drv : ctl_scl_rel;

  // monitor word: SDA drive, SDA live, SCL drive, SCL live
  assign mon = {sda_drv_i, sda_s, scl_out, scl_s};

  // R8: after a STOP completes the clock stays released
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && ctl_run) |=> (ctl_run ? scl_out : 1'b1));

endmodule

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

  localparam int CW  = 16;
  localparam int STG = 2;
  localparam int MAXF = (1 << CW) - 1;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_period, cfg_low, cfg_cond, cfg_dsu;
  logic ctl_run = 1'b1, ctl_scl_rel = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic sda_drv = 1'b1;
  logic hold_low = 1'b0;
  logic op_ready, scl_out, stb_sda_set, stb_sample, stb_cond, stb_done, stretch;
  logic [3:0] mon;
  wire scl_line = scl_out & ~hold_low;
  wire sda_line = sda_drv;

  int n_vec = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  i2c_scl_timer #(.CNT_W(CW), .SYNC_STAGES(STG)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_cond(cfg_cond), .cfg_dsu(cfg_dsu),
    .ctl_run(ctl_run), .ctl_scl_rel(ctl_scl_rel),
    .op_valid(op_valid), .op_code(op_code), .op_ready(op_ready),
    .sda_drv_i(sda_drv), .scl_in(scl_line), .sda_in(sda_line),
    .scl_out(scl_out), .stb_sda_set(stb_sda_set), .stb_sample(stb_sample),
    .stb_cond(stb_cond), .stb_done(stb_done), .stretch(stretch), .mon(mon)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 wait-free, 2 low, 3 wait-high, 4 high, 5 setup, 6 hold
  int  mph = 0, mcnt = 0, mown = 0, mfree = 0, mop = 0;
  bit  qs[STG];
  bit  qd[STG];

  function automatic int fl(input int v); return (v < 1) ? 1 : v; endfunction
  function automatic int fh();
    int d; d = int'(cfg_period) - fl(int'(cfg_low));
    return (d < 1) ? 1 : d;
  endfunction
  function automatic int fsda();
    int d; d = fl(int'(cfg_low)) - fl(int'(cfg_dsu));
    return (d < 0) ? 0 : d;
  endfunction
  function automatic bit m_released(); return !(mph == 2 || (mph == 0 && mown != 0)); endfunction
  function automatic bit m_scl(); return ctl_run ? m_released() : ctl_scl_rel; endfunction
  function automatic bit m_hold_last();
    return (mop == 3) ? (mcnt == 0) : (mcnt == fl(int'(cfg_cond)) - 1);
  endfunction

  task automatic model_step();
    bit line; bit sy; bit hl;
    int nph, ncnt, nown, nop, nfree, lo, hi, cd;
    line = m_scl() & ~hold_low;
    sy = qs[STG-1];
    lo = fl(int'(cfg_low)); hi = fh(); cd = fl(int'(cfg_cond));
    hl = m_hold_last();
    nph = mph; ncnt = mcnt; nown = mown; nop = mop; nfree = mfree;
    if (!ctl_run) begin
      nph = 0; ncnt = 0; nown = 0; nfree = 0;
    end else begin
      if ((mph == 0 || mph == 1) && mown == 0) nfree = (mfree < MAXF) ? mfree + 1 : MAXF;
      if (mph == 6 && mop == 3 && hl) nfree = 0;
      case (mph)
        0: if (op_valid && ((op_code == 2'd1) ? (mown == 0) : (mown != 0))) begin
             nop = int'(op_code); ncnt = 0; nph = (op_code == 2'd1) ? 1 : 2;
           end
        1: if (mfree >= lo) begin nph = 6; ncnt = 0; end
        2: if (mcnt == lo - 1) begin nph = 3; ncnt = 0; end else ncnt = mcnt + 1;
        3: if (sy) begin nph = (mop == 0) ? 4 : 5; ncnt = 0; end
        4: if (mcnt == hi - 1) begin nph = 0; ncnt = 0; end else ncnt = mcnt + 1;
        5: if (mcnt == cd - 1) begin nph = 6; ncnt = 0; end else ncnt = mcnt + 1;
        6: if (hl) begin nph = 0; ncnt = 0; nown = (mop != 3); end else ncnt = mcnt + 1;
        default: nph = 0;
      endcase
    end
    mph = nph; mcnt = ncnt; mown = nown; mop = nop; mfree = nfree;
    for (int i = STG - 1; i > 0; i--) begin qs[i] = qs[i-1]; qd[i] = qd[i-1]; end
    qs[0] = line; qd[0] = sda_line;
  endtask

  task automatic compare_all();
    bit r; int hi;
    r = ctl_run; hi = fh();
    check("R2/R10 scl_out", int'(scl_out), int'(m_scl()));
    check("R10 op_ready", int'(op_ready), int'(r && mph == 0));
    check("R3 stb_sda_set", int'(stb_sda_set), int'(r && mph == 2 && mcnt == fsda()));
    check("R4 stb_sample", int'(stb_sample), int'(r && mph == 4 && mcnt == 0));
    check("R6/R7/R8 stb_cond", int'(stb_cond), int'(r && mph == 6 && mcnt == 0));
    check("R2/R8 stb_done", int'(stb_done),
          int'(r && ((mph == 4 && mcnt == hi - 1) || (mph == 6 && m_hold_last()))));
    check("R5 stretch", int'(stretch), int'(r && mph == 3 && !qs[STG-1]));
    check("R11 mon", int'(mon), int'({sda_drv, qd[STG-1], m_scl(), qs[STG-1]}));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mph = 0; mcnt = 0; mown = 0; mfree = 0; mop = 0;
      for (int i = 0; i < STG; i++) begin qs[i] = 1'b1; qd[i] = 1'b1; end
    end else begin
      model_step();
      #1 compare_all();
    end
    if (cyc == WDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_op(input logic [1:0] code);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_code = code;
    @(negedge clk);
    op_valid = 1'b0;
    while (!op_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cfg_period = 16'd20; cfg_low = 16'd11; cfg_cond = 16'd10; cfg_dsu = 16'd3;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl released", int'(scl_out), 1);
    check("R1 ready", int'(op_ready), 1);
    check("R1 stretch", int'(stretch), 0);
    check("R1 mon", int'(mon), 4'hF);

    // R9: a bit on a free bus is ignored
    op_valid = 1'b1; op_code = 2'd0;
    @(negedge clk); op_valid = 1'b0;
    idle(2);
    check("R9 bit on free bus, scl", int'(scl_out), 1);
    check("R9 bit on free bus, ready", int'(op_ready), 1);

    // START, bits with varying SDA, one bit stretched by a slave
    do_op(2'd1);
    check("R6 owned after start", int'(scl_out), 0);
    sda_drv = 1'b0; do_op(2'd0);
    sda_drv = 1'b1; do_op(2'd0);
    hold_low = 1'b1;
    fork
      do_op(2'd0);
      begin idle(30); hold_low = 1'b0; end
    join
    sda_drv = 1'b0; do_op(2'd0);

    // R11: synchroniser lag on the SDA monitor bit
    sda_drv = 1'b1;
    @(posedge clk); #2 check("R11 sda lag 1", int'(mon[2]), 0);
    @(posedge clk); #2 check("R11 sda lag 2", int'(mon[2]), 1);

    // R9: START on an owned bus is ignored
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'd1;
    @(negedge clk); op_valid = 1'b0;
    idle(2);
    check("R9 start on owned bus, scl", int'(scl_out), 0);
    check("R9 start on owned bus, ready", int'(op_ready), 1);

    do_op(2'd2);
    do_op(2'd0);
    do_op(2'd3);
    check("R8 released after stop", int'(scl_out), 1);
    // START straight after STOP: bus-free wait
    do_op(2'd1);
    do_op(2'd0);
    do_op(2'd3);

    // R10 recovery: software drives SCL
    ctl_run = 1'b0; ctl_scl_rel = 1'b0;
    idle(3);
    check("R10 scl follows release bit low", int'(scl_out), 0);
    check("R10 not ready", int'(op_ready), 0);
    ctl_scl_rel = 1'b1;
    idle(2);
    check("R10 scl follows release bit high", int'(scl_out), 1);
    ctl_run = 1'b1;
    do_op(2'd1);
    do_op(2'd3);

    // clamped configuration
    cfg_period = 16'd8; cfg_low = 16'd8; cfg_cond = 16'd0; cfg_dsu = 16'd9;
    do_op(2'd1);
    do_op(2'd0);
    do_op(2'd0);
    do_op(2'd2);
    do_op(2'd3);

    // recovery in the middle of a bit
    cfg_period = 16'd20; cfg_low = 16'd11; cfg_cond = 16'd10; cfg_dsu = 16'd3;
    do_op(2'd1);
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'd0;
    @(negedge clk); op_valid = 1'b0;
    idle(3);
    ctl_run = 1'b0; ctl_scl_rel = 1'b1;
    idle(2);
    check("R10 takeover mid-bit", int'(scl_out), 1);
    ctl_run = 1'b1;
    idle(1);
    check("R10 free bus after takeover", int'(scl_out), 1);
    do_op(2'd1);
    do_op(2'd3);
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule